// File: doc/BRIEF.md
# Boot Overlay Address Decoder

This block turns a 24-bit processor byte address into a memory target, an offset inside that target, and a grant or deny verdict. The address space is split into 64 slots of 256 KB, picked by the six top address bits. Each slot holds a target code, a read-permit bit, a write-permit bit and a slot base (the slot's position inside its target, in 256 KB units). The slot table is filled for three targets: a boot ROM at the top of the space, chip RAM from address zero, and an expansion RAM window that software places at run time.

At reset a ROM shadow covers the lowest 512 KB read-only, so the processor fetches its start-up code from ROM at address zero. A two-state controller follows the level of the overlay request. The state OVL_SHADOW (the reset state) moves to OVL_CLEAR when the request is low, and OVL_CLEAR moves back to OVL_SHADOW when the request is high. Either move first rewrites every chip RAM slot as read/write chip RAM. A move into OVL_SHADOW then points the low two slots back at the ROM. A request equal to the present state stays in place and writes nothing. A load strobe with a base byte (address bits 23..16) maps the expansion window over its full size. Lookups are combinational from the registered table, and every table write shows in the cycle after the clock edge that takes it.

Top module: `boot_overlay_decoder`

## Requirements
- R1: Slot index is acc_addr[23:18]. When granted, tgt_offset equals the slot base times 0x40000 plus acc_addr[17:0], so a target spanning several slots sees linear offsets.
- R2: Slot 63 (0xFC0000 to 0xFFFFFF) maps to ROM (tgt_sel code 1) with read permission only and offset starting at 0, until an expansion load overwrites it.
- R3: After reset the overlay is on: 0x000000 to 0x07FFFF reads ROM at offset equal to the address, read-only. Chip slots above the low 512 KB are read/write chip RAM, and all other slots except slot 63 are unmapped.
- R4: When ovl_req is low while the overlay is on, every chip RAM slot becomes read/write chip RAM (code 2) with offset equal to the address. This includes slots an expansion load had taken.
- R5: When ovl_req is high while the overlay is off, chip RAM slots are rewritten as in R4 and then the low two slots become read-only ROM at offset equal to the address.
- R6: An ovl_req level equal to the present overlay state changes no slot.
- R7: A pulse on exp_load maps EXP_KB/256 slots from slot exp_base[7:2] upward as read/write expansion RAM (code 3), with offsets from 0. exp_base[1:0] are ignored, slots past 63 are dropped, and slots of an earlier window are kept.
- R8: If an overlay change and an expansion load occur in the same cycle, the overlay writes go first and the expansion write wins on any overlapping slot.
- R9: An access to an unmapped slot, a write to a slot without write permission, or a read without read permission raises acc_deny, clears acc_grant and drives tgt_sel to 0 (none).
- R10: While acc_valid is low, acc_grant, acc_deny and tgt_sel are all 0.
- R11: Table changes appear in lookups only after the clock edge that takes the overlay change or load, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the start-up table |
| ovl_req | input | 1 | Requested overlay level (1 = ROM shadows low memory) |
| exp_load | input | 1 | One-cycle strobe to place the expansion window |
| exp_base | input | 8 | Expansion base address bits 23..16 |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Byte address |
| tgt_sel | output | 2 | Target: 0 none, 1 ROM, 2 chip RAM, 3 expansion RAM |
| tgt_offset | output | 24 | Byte offset inside the selected target |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |

## Verification
An overlay change and an expansion load can be taken at the same clock edge and aim at the same low slots. The bench raises ovl_req together with a load at base 0x00 and then expects expansion RAM at address zero, not ROM. It also mixes both kinds of update at random with accesses, and compares every access against a bench model that applies the overlay writes before the expansion writes.

// File: rtl/bod_pkg.sv
package bod_pkg;
    localparam int IDX_W  = 6;
    localparam int ADDR_W = 24;
    localparam int OFF_W  = ADDR_W - IDX_W;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_CHIP = 2'd2,
        TGT_EXP  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic             rd;
        logic             wr;
        logic [IDX_W-1:0] base;
    } slot_t;
endpackage

// File: rtl/bod_overlay_fsm.sv
module bod_overlay_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ovl_req,
    output logic remap_chip,
    output logic shadow_rom
);
    typedef enum logic {OVL_SHADOW = 1'b0, OVL_CLEAR = 1'b1} ovl_state_e;

    ovl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVL_SHADOW: if (!ovl_req) state_d = OVL_CLEAR;
            OVL_CLEAR:  if (ovl_req)  state_d = OVL_SHADOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVL_SHADOW;
        else        state_q <= state_d;
    end

    always_comb begin
        remap_chip = 1'b0;
        shadow_rom = 1'b0;
        unique case (state_q)
            OVL_SHADOW: remap_chip = !ovl_req;
            OVL_CLEAR: begin
                remap_chip = ovl_req;
                shadow_rom = ovl_req;
            end
        endcase
    end

    AST_SAME_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == OVL_SHADOW) == ovl_req) |=> $stable(state_q)); // R6

    AST_SHADOW_NEEDS_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_rom |-> remap_chip); // R5
endmodule

// File: rtl/bod_region_table.sv
module bod_region_table
    import bod_pkg::*;
#(
    parameter int CHIP_SLOTS = 2,
    parameter int OVL_SLOTS  = 2,
    parameter int ROM_SLOTS  = 1,
    parameter int EXP_SLOTS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             remap_chip,
    input  logic             shadow_rom,
    input  logic             exp_load,
    input  logic [IDX_W-1:0] exp_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_slot
);
    localparam int NSLOT    = 1 << IDX_W;
    localparam int ROM_LOW  = NSLOT - ROM_SLOTS;

    slot_t tbl_q [NSLOT];

    function automatic slot_t start_slot(input int i);
        slot_t s;
        s = '{tgt: TGT_NONE, rd: 1'b0, wr: 1'b0, base: '0};
        if (i >= ROM_LOW)
            s = '{tgt: TGT_ROM, rd: 1'b1, wr: 1'b0, base: IDX_W'(i - ROM_LOW)};
        else if (i < OVL_SLOTS)
            s = '{tgt: TGT_ROM, rd: 1'b1, wr: 1'b0, base: IDX_W'(i)};
        else if (i < CHIP_SLOTS)
            s = '{tgt: TGT_CHIP, rd: 1'b1, wr: 1'b1, base: IDX_W'(i)};
        return s;
    endfunction

    logic [IDX_W:0] win_lo, win_hi;
    assign win_lo = {1'b0, exp_idx};
    assign win_hi = win_lo + (IDX_W+1)'(EXP_SLOTS);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [IDX_W:0] GIDX = (IDX_W+1)'(g);
        slot_t ent_q, ent_d;
        logic  in_win;

        assign in_win = (GIDX >= win_lo) && (GIDX < win_hi);

        always_comb begin
            ent_d = ent_q;
            if (remap_chip && (g < CHIP_SLOTS))
                ent_d = '{tgt: TGT_CHIP, rd: 1'b1, wr: 1'b1, base: IDX_W'(g)};
            if (shadow_rom && (g < OVL_SLOTS))
                ent_d = '{tgt: TGT_ROM, rd: 1'b1, wr: 1'b0, base: IDX_W'(g)};
            if (exp_load && in_win)
                ent_d = '{tgt: TGT_EXP, rd: 1'b1, wr: 1'b1,
                          base: IDX_W'(g) - exp_idx};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= start_slot(g);
            else        ent_q <= ent_d;
        end

        assign tbl_q[g] = ent_q;
    end

    assign rd_slot = tbl_q[rd_idx];

    AST_SHADOW_LOW_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_rom && !exp_load) |=>
        (tbl_q[0].tgt == TGT_ROM && tbl_q[0].rd && !tbl_q[0].wr)); // R5

    AST_CHIP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_chip && !shadow_rom && !exp_load) |=>
        (tbl_q[0].tgt == TGT_CHIP && tbl_q[0].wr && tbl_q[0].base == '0)); // R4

    AST_EXP_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
        exp_load |=>
        (tbl_q[$past(exp_idx)].tgt == TGT_EXP && tbl_q[$past(exp_idx)].base == '0)); // R7
endmodule

// File: rtl/bod_lookup.sv
module bod_lookup
    import bod_pkg::*;
(
    input  slot_t             slot,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output tgt_e              sel,
    output logic [ADDR_W-1:0] offset,
    output logic              grant,
    output logic              deny
);
    logic mapped, allowed;

    always_comb begin
        mapped  = (slot.tgt != TGT_NONE);
        allowed = acc_write ? slot.wr : slot.rd;
        grant   = acc_valid && mapped && allowed;
        deny    = acc_valid && !(mapped && allowed);
        sel     = grant ? slot.tgt : TGT_NONE;
        offset  = {slot.base, acc_addr[OFF_W-1:0]};
    end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import bod_pkg::*;
#(
    parameter int CHIP_KB = 512,
    parameter int OVL_KB  = 512,
    parameter int ROM_KB  = 256,
    parameter int EXP_KB  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_req,
    input  logic              exp_load,
    input  logic [7:0]        exp_base,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        tgt_sel,
    output logic [ADDR_W-1:0] tgt_offset,
    output logic              acc_grant,
    output logic              acc_deny
);
    localparam int SLOT_KB    = 1 << (OFF_W - 10);
    localparam int CHIP_SLOTS = CHIP_KB / SLOT_KB;
    localparam int OVL_SLOTS  = OVL_KB / SLOT_KB;
    localparam int ROM_SLOTS  = ROM_KB / SLOT_KB;
    localparam int EXP_SLOTS  = EXP_KB / SLOT_KB;
    localparam int BASE_DROP  = OFF_W - 16;

    logic  remap_chip, shadow_rom;
    slot_t cur_slot;
    tgt_e  sel_e;

    bod_overlay_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovl_req    (ovl_req),
        .remap_chip (remap_chip),
        .shadow_rom (shadow_rom)
    );

    bod_region_table #(
        .CHIP_SLOTS (CHIP_SLOTS),
        .OVL_SLOTS  (OVL_SLOTS),
        .ROM_SLOTS  (ROM_SLOTS),
        .EXP_SLOTS  (EXP_SLOTS)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .remap_chip (remap_chip),
        .shadow_rom (shadow_rom),
        .exp_load   (exp_load),
        .exp_idx    (exp_base[7:BASE_DROP]),
        .rd_idx     (acc_addr[ADDR_W-1:OFF_W]),
        .rd_slot    (cur_slot)
    );

    bod_lookup u_lookup (
        .slot      (cur_slot),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .sel       (sel_e),
        .offset    (tgt_offset),
        .grant     (acc_grant),
        .deny      (acc_deny)
    );

    assign tgt_sel = sel_e;

    AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_deny)); // R9

    AST_SEL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel != 2'd0) |-> acc_grant); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_grant && !acc_deny && tgt_sel == 2'd0)); // R10

    AST_RO_WRITE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !cur_slot.wr) |-> acc_deny); // R9
endmodule

// File: tb/boot_overlay_decoder_bench.sv
module boot_overlay_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ovl_req = 1'b1;
    logic        exp_load = 1'b0;
    logic [7:0]  exp_base = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [1:0]  tgt_sel;
    logic [23:0] tgt_offset;
    logic        acc_grant, acc_deny;

    int checks = 0;
    int errors = 0;

    // bench model of the slot table
    logic [1:0] m_tgt [64];
    logic       m_rd  [64];
    logic       m_wr  [64];
    logic [5:0] m_base[64];
    logic       m_ovl;

    always #4 clk = ~clk;

    boot_overlay_decoder u_boot_overlay_decoder (
        .clk(clk), .rst_n(rst_n), .ovl_req(ovl_req), .exp_load(exp_load),
        .exp_base(exp_base), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .tgt_sel(tgt_sel), .tgt_offset(tgt_offset),
        .acc_grant(acc_grant), .acc_deny(acc_deny)
    );

    task automatic set_slot(int i, logic [1:0] t, logic r, logic w, int b);
        m_tgt[i] = t; m_rd[i] = r; m_wr[i] = w; m_base[i] = 6'(b);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) set_slot(i, 2'd0, 1'b0, 1'b0, 0);
        set_slot(63, 2'd1, 1'b1, 1'b0, 0);
        set_slot(0, 2'd1, 1'b1, 1'b0, 0);
        set_slot(1, 2'd1, 1'b1, 1'b0, 1);
        m_ovl = 1'b1;
    endtask

    task automatic model_apply(logic req, logic ld, logic [7:0] base);
        if (req != m_ovl) begin
            for (int i = 0; i < 2; i++) set_slot(i, 2'd2, 1'b1, 1'b1, i);
            if (req) for (int i = 0; i < 2; i++) set_slot(i, 2'd1, 1'b1, 1'b0, i);
            m_ovl = req;
        end
        if (ld) begin
            for (int k = 0; k < 4; k++)
                if (int'(base[7:2]) + k < 64) set_slot(int'(base[7:2]) + k, 2'd3, 1'b1, 1'b1, k);
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample before posedge, model update at posedge
    task automatic step(logic v, logic w, logic [23:0] a, logic req, logic ld,
                        logic [7:0] base, bit do_check, string tag);
        logic [5:0] s;
        logic ok;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a;
        ovl_req = req; exp_load = ld; exp_base = base;
        #2;
        if (do_check) begin
            s  = a[23:18];
            ok = v && (m_tgt[s] != 2'd0) && (w ? m_wr[s] : m_rd[s]);
            chk({tag, " grant"}, 32'(acc_grant), 32'(ok));
            chk({tag, " deny"}, 32'(acc_deny), 32'(v && !ok));
            chk({tag, " sel"}, 32'(tgt_sel), ok ? 32'(m_tgt[s]) : 32'd0);
            if (ok) chk({tag, " offset"}, 32'(tgt_offset), {8'd0, m_base[s], a[17:0]});
        end
        @(posedge clk);
        model_apply(req, ld, base);
    endtask

    task automatic expect_acc(logic w, logic [23:0] a, logic [1:0] es,
                              logic [23:0] eo, logic eg, string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; exp_load = 1'b0;
        #2;
        chk({tag, " grant"}, 32'(acc_grant), 32'(eg));
        chk({tag, " deny"}, 32'(acc_deny), 32'(!eg));
        chk({tag, " sel"}, 32'(tgt_sel), 32'(es));
        if (eg) chk({tag, " offset"}, 32'(tgt_offset), 32'(eo));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset map
        expect_acc(1'b0, 24'h000000, 2'd1, 24'h000000, 1'b1, "R3 rom at zero");
        expect_acc(1'b0, 24'h040010, 2'd1, 24'h040010, 1'b1, "R3 R1 rom second slot");
        expect_acc(1'b1, 24'h000100, 2'd0, 24'h0,      1'b0, "R9 write shadow");
        expect_acc(1'b0, 24'h080000, 2'd0, 24'h0,      1'b0, "R9 R3 unmapped");
        expect_acc(1'b0, 24'hFC1234, 2'd1, 24'h001234, 1'b1, "R2 top rom");
        expect_acc(1'b1, 24'hFC0000, 2'd0, 24'h0,      1'b0, "R2 rom write");
        @(negedge clk) acc_valid = 1'b0; #2;
        chk("R10 idle grant", 32'(acc_grant), 0);
        chk("R10 idle deny", 32'(acc_deny), 0);
        chk("R10 idle sel", 32'(tgt_sel), 0);

        // overlay off: before the edge still ROM, after it chip RAM
        step(1'b1, 1'b0, 24'h000000, 1'b0, 1'b0, 8'h00, 1'b1, "R11 pre-edge");
        expect_acc(1'b0, 24'h000000, 2'd2, 24'h000000, 1'b1, "R4 R11 chip at zero");
        expect_acc(1'b1, 24'h052345, 2'd2, 24'h052345, 1'b1, "R4 chip write");
        step(1'b1, 1'b0, 24'h000000, 1'b0, 1'b0, 8'h00, 1'b0, "R6");
        expect_acc(1'b1, 24'h000010, 2'd2, 24'h000010, 1'b1, "R6 same level");

        // expansion window and relocation
        step(1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 8'h21, 1'b0, "R7");
        expect_acc(1'b0, 24'h200000, 2'd3, 24'h000000, 1'b1, "R7 exp base");
        expect_acc(1'b1, 24'h2C0004, 2'd3, 24'h0C0004, 1'b1, "R7 exp last");
        expect_acc(1'b0, 24'h300000, 2'd0, 24'h0,      1'b0, "R7 past window");
        step(1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 8'h40, 1'b0, "R7");
        expect_acc(1'b0, 24'h440008, 2'd3, 24'h040008, 1'b1, "R7 relocated");
        expect_acc(1'b0, 24'h200000, 2'd3, 24'h000000, 1'b1, "R7 old kept");
        step(1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 8'hF8, 1'b0, "R7");
        expect_acc(1'b1, 24'hFC0000, 2'd3, 24'h040000, 1'b1, "R7 top clip");

        // overlay on and load at zero in one cycle
        step(1'b0, 1'b0, 24'h0, 1'b1, 1'b1, 8'h00, 1'b0, "R8");
        expect_acc(1'b0, 24'h000000, 2'd3, 24'h000000, 1'b1, "R8 exp wins");
        step(1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 8'h00, 1'b0, "R4");
        expect_acc(1'b0, 24'h040000, 2'd2, 24'h040000, 1'b1, "R4 chip over exp");
        expect_acc(1'b0, 24'h080000, 2'd3, 24'h080000, 1'b1, "R4 exp above chip");
        step(1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 8'h00, 1'b0, "R5");
        expect_acc(1'b0, 24'h000020, 2'd1, 24'h000020, 1'b1, "R5 shadow back");
        expect_acc(1'b1, 24'h000020, 2'd0, 24'h0,      1'b0, "R5 shadow ro");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 7)
                step(1'b1, 1'($urandom), 24'($urandom), m_ovl, 1'b0, 8'h00, 1'b1, "R1 R9 random");
            else if (r < 9)
                step(1'b1, 1'($urandom), 24'($urandom), 1'($urandom), ($urandom % 3) == 0,
                     8'($urandom), 1'b1, "R8 R11 random update");
            else
                step(1'b0, 1'b0, 24'($urandom), m_ovl, 1'b0, 8'h00, 1'b1, "R10 random idle");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule